// File: doc/BRIEF.md
# Programmable Reflected CRC Engine

This block computes a cyclic redundancy check over a stream of bytes. It consumes each byte least significant bit first, one bit per clock, so a byte takes eight clock cycles. The generator polynomial and the start value are written at run time, both in reflected (LSB-first) form. A 32-bit polynomial register therefore serves every CRC width up to 32 bits: a narrower polynomial sits in the low bits, and the engine needs no width setting.

Software first writes the polynomial and the start value. It then offers bytes through a valid/ready handshake. The running remainder is visible on an output at all times, and the engine adds no final XOR and no output reflection. The remainder register is the only state a computation depends on. Reading it and writing it back later as the start value therefore lets one CRC span several separate data areas, or lets several independent computations share the engine.

Top module: `crc_serial_engine`

## Requirements
- R1: After reset the remainder and the polynomial are zero, `in_ready` is 1 and `done` is 0.
- R2: A start-value write (`seed_we`=1) made while `in_ready` is 1 shows up on `remainder` in the next cycle.
- R3: Each accepted byte is processed from bit 0 up to bit 7. On every bit-step the remainder shifts right by one, and it is then XORed with the polynomial when the old remainder bit 0 XOR the data bit is 1. The final remainder equals that of a bit-serial model.
- R4: After a byte is accepted, `in_ready` stays low for exactly 8 cycles. `done` is high for one cycle, the first cycle in which `in_ready` is high again.
- R5: A polynomial and start value that fit in 16 bits leave bits 31:16 of `remainder` at zero. With polynomial 0xA001, start 0 and the ASCII bytes "123456789", the result is 0xBB3D.
- R6: Processing area A, then area B with A's result as the start value, gives the same remainder as processing A followed by B in one stream.
- R7: Restoring a saved remainder as the start value resumes that computation exactly, even after another computation has used the engine in between.
- R8: Start-value and polynomial writes made while `in_ready` is 0 are dropped and do not affect the result.
- R9: When a start-value write and an accepted byte fall in the same idle cycle, the byte is processed from the newly written start value.
- R10: No final XOR and no reflection are applied. With polynomial 0xEDB88320, start 0xFFFFFFFF and "123456789", `remainder` reads 0x340BC6D9.
- R11: While idle with no start-value write, `remainder` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| poly_we | input | 1 | Write strobe for the polynomial (taken only when idle) |
| poly_in | input | 32 | Reflected polynomial to write |
| seed_we | input | 1 | Write strobe for the start value (taken only when idle) |
| seed_in | input | 32 | Start value to write into the remainder |
| in_valid | input | 1 | A data byte is offered |
| in_byte | input | 8 | Data byte |
| in_ready | output | 1 | Engine is idle and will accept a byte |
| done | output | 1 | One-cycle pulse when the last bit-step of a byte completes |
| remainder | output | 32 | Current remainder, raw |

## Verification
The bench builds the engine at its default 32-bit register width and 8-bit byte width. It sweeps all 256 single-byte values under both a reflected 32-bit polynomial and a reflected 16-bit polynomial, and compares every result and every busy window against an arithmetic bit-serial model. Longer nine-byte messages bring the well-known check values within reach. These messages also exercise chaining across split areas, context save and restore, writes dropped while busy, and a start-value write that coincides with a byte.

// File: rtl/crc_pkg.sv
package crc_pkg;
    localparam int CRC_W  = 32;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef logic [CRC_W-1:0]  crc_word_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  bitcnt_t;

    typedef struct packed {
        crc_word_t rem;
        crc_word_t poly;
        byte_t     data;
    } dp_state_t;

    typedef struct packed {
        bitcnt_t left;
        logic    done;
    } ctrl_state_t;
endpackage

// File: rtl/crc_bit_step.sv
module crc_bit_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] poly_i,
    input  logic         din_i,
    output logic [W-1:0] rem_o
);
    logic [W-1:0] shifted;

    always_comb begin
        shifted = rem_i >> 1;
        // feedback taken from the bit that falls off, mixed with the data bit
        if (rem_i[0] ^ din_i) begin
            rem_o = shifted ^ poly_i;
        end else begin
            rem_o = shifted;
        end
    end
endmodule

// File: rtl/crc_byte_ctrl.sv
module crc_byte_ctrl
    import crc_pkg::*;
#(
    parameter int BITS = BYTE_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    output logic ready_o,
    output logic accept_o,
    output logic step_o,
    output logic done_o
);
    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        ready_o  = (st_q.left == '0);
        accept_o = valid_i && ready_o;
        step_o   = !ready_o;
        st_d.done = (st_q.left == bitcnt_t'(1));
        if (accept_o) begin
            st_d.left = bitcnt_t'(BITS);
        end else if (step_o) begin
            st_d.left = st_q.left - bitcnt_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;
endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
    import crc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        poly_we,
    input  logic [31:0] poly_in,
    input  logic        seed_we,
    input  logic [31:0] seed_in,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    output logic        in_ready,
    output logic        done,
    output logic [31:0] remainder
);
    dp_state_t state_d, state_q;
    logic      accept, step;
    crc_word_t step_rem;

    crc_byte_ctrl #(.BITS(BYTE_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (in_valid),
        .ready_o  (in_ready),
        .accept_o (accept),
        .step_o   (step),
        .done_o   (done)
    );

    crc_bit_step #(.W(CRC_W)) step_i (
        .rem_i  (state_q.rem),
        .poly_i (state_q.poly),
        .din_i  (state_q.data[0]),
        .rem_o  (step_rem)
    );

    always_comb begin
        state_d = state_q;
        if (in_ready) begin
            if (seed_we) state_d.rem  = seed_in;
            if (poly_we) state_d.poly = poly_in;
        end
        if (accept) begin
            state_d.data = in_byte;
        end
        if (step) begin
            state_d.rem  = step_rem;
            state_d.data = state_q.data >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign remainder = state_q.rem;
endmodule

// File: rtl/crc_serial_engine_chk.sv
module crc_serial_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        seed_we,
    input logic [31:0] seed_in,
    input logic        done,
    input logic [31:0] remainder,
    input logic [31:0] poly_q
);
    localparam int STEPS = 8;
    localparam int CW    = $clog2(STEPS + 2);
    logic [CW-1:0] since_acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_acc_q <= '0;
        end else if (in_valid && in_ready) begin
            since_acc_q <= '0;
        end else if (!in_ready) begin
            since_acc_q <= since_acc_q + 1'b1;
        end
    end

    // R4
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R4
    done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (in_ready && since_acc_q == CW'(STEPS)));

    // R2
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && seed_we) |=> (remainder == $past(seed_in)));

    // R8
    poly_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> $stable(poly_q));

    // R11
    rem_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !seed_we) |=> $stable(remainder));
endmodule

bind crc_serial_engine crc_serial_engine_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .seed_we   (seed_we),
    .seed_in   (seed_in),
    .done      (done),
    .remainder (remainder),
    .poly_q    (state_q.poly)
);

// File: tb/crc_serial_engine_tb_top.sv
module crc_serial_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        poly_we = 1'b0;
    logic [31:0] poly_in = '0;
    logic        seed_we = 1'b0;
    logic [31:0] seed_in = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_ready, done;
    logic [31:0] remainder;

    int n_run  = 0;
    int n_fail = 0;

    localparam logic [31:0] P32 = 32'hEDB88320;
    localparam logic [31:0] P16 = 32'h0000A001;
    logic [7:0] msg [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};

    always #10 clk = ~clk;

    crc_serial_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .poly_we(poly_we), .poly_in(poly_in),
        .seed_we(seed_we), .seed_in(seed_in),
        .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .done(done), .remainder(remainder)
    );

    function automatic logic [31:0] model_byte(logic [31:0] c, logic [7:0] b, logic [31:0] p);
        for (int i = 0; i < 8; i++) begin
            if ((c[0] ^ b[i]) == 1'b1) c = (c >> 1) ^ p;
            else                       c = c >> 1;
        end
        return c;
    endfunction

    function automatic logic [31:0] model_msg(logic [31:0] c, int first, int last, logic [31:0] p);
        for (int i = first; i <= last; i++) c = model_byte(c, msg[i], p);
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input bit ws, input logic [31:0] s, input bit wp, input logic [31:0] p);
        @(negedge clk);
        seed_we = ws; seed_in = s; poly_we = wp; poly_in = p;
        @(negedge clk);
        seed_we = 1'b0; poly_we = 1'b0;
    endtask

    // push one byte; returns cycles with in_ready low and done on return
    task automatic push(input logic [7:0] b, output int low, output logic dn);
        @(negedge clk);
        in_valid = 1'b1; in_byte = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        low = 0;
        while (!in_ready) begin
            low++;
            @(negedge clk);
        end
        dn = done;
    endtask

    task automatic push_msg(input int first, input int last);
        int l; logic d;
        for (int i = first; i <= last; i++) push(msg[i], l, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R4 watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int low; logic dn;
        logic [31:0] exp, saved;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(remainder == 32'h0 && in_ready && !done, "R1", remainder, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dut_i.remainder == 32'h0 && in_ready, "R1", remainder, 32'h0);

        // R2 seed load visible next cycle
        write_cfg(1'b1, 32'hFFFFFFFF, 1'b1, P32);
        check(remainder == 32'hFFFFFFFF, "R2", remainder, 32'hFFFFFFFF);

        // R10 / R3 standard 32-bit check message, raw remainder
        push_msg(0, 8);
        check(remainder == 32'h340BC6D9, "R10", remainder, 32'h340BC6D9);
        exp = model_msg(32'hFFFFFFFF, 0, 8, P32);
        check(remainder == exp, "R3", remainder, exp);

        // R11 hold while idle
        repeat (5) @(negedge clk);
        check(remainder == exp, "R11", remainder, exp);

        // R3 / R4 sweep of all bytes, 32-bit polynomial
        for (int v = 0; v < 256; v++) begin
            write_cfg(1'b1, 32'hFFFFFFFF, 1'b0, 32'h0);
            push(8'(v), low, dn);
            exp = model_byte(32'hFFFFFFFF, 8'(v), P32);
            check(remainder == exp, "R3", remainder, exp);
            check(low == 8, "R4", low, 8);
            check(dn == 1'b1, "R4", {31'h0, dn}, 32'h1);
            @(negedge clk);
            check(done == 1'b0, "R4", {31'h0, done}, 32'h0);
        end

        // R5 16-bit polynomial: sweep and check message
        write_cfg(1'b1, 32'h0, 1'b1, P16);
        for (int v = 0; v < 256; v++) begin
            write_cfg(1'b1, 32'h0000FFFF & (32'(v) * 32'h0101), 1'b0, 32'h0);
            push(8'(v), low, dn);
            exp = model_byte(32'h0000FFFF & (32'(v) * 32'h0101), 8'(v), P16);
            check(remainder == exp && remainder[31:16] == 16'h0, "R5", remainder, exp);
        end
        write_cfg(1'b1, 32'h0, 1'b0, 32'h0);
        push_msg(0, 8);
        check(remainder == 32'h0000BB3D, "R5", remainder, 32'h0000BB3D);

        // R6 chained two blocks
        write_cfg(1'b1, 32'hFFFFFFFF, 1'b1, P32);
        push_msg(0, 3);
        saved = remainder;
        write_cfg(1'b1, saved, 1'b0, 32'h0);
        push_msg(4, 8);
        check(remainder == 32'h340BC6D9, "R6", remainder, 32'h340BC6D9);

        // R7 context switch and restore
        write_cfg(1'b1, 32'hFFFFFFFF, 1'b1, P32);
        push_msg(0, 4);
        saved = remainder;
        write_cfg(1'b1, 32'h0, 1'b1, P16);
        push_msg(0, 8);
        check(remainder == 32'h0000BB3D, "R7", remainder, 32'h0000BB3D);
        write_cfg(1'b1, saved, 1'b1, P32);
        push_msg(5, 8);
        check(remainder == 32'h340BC6D9, "R7", remainder, 32'h340BC6D9);

        // R8 writes while busy are dropped
        write_cfg(1'b1, 32'h12345678, 1'b1, P32);
        @(negedge clk);
        in_valid = 1'b1; in_byte = 8'hA5;
        @(negedge clk);
        in_valid = 1'b0;
        seed_we = 1'b1; seed_in = 32'hDEADBEEF; poly_we = 1'b1; poly_in = 32'h0000A001;
        repeat (3) @(negedge clk);
        seed_we = 1'b0; poly_we = 1'b0;
        while (!in_ready) @(negedge clk);
        exp = model_byte(32'h12345678, 8'hA5, P32);
        check(remainder == exp, "R8", remainder, exp);
        push(8'h3C, low, dn);
        exp = model_byte(exp, 8'h3C, P32);
        check(remainder == exp, "R8", remainder, exp);

        // R9 seed write coinciding with an accepted byte
        @(negedge clk);
        seed_we = 1'b1; seed_in = 32'h0F0F0F0F; in_valid = 1'b1; in_byte = 8'h5A;
        @(negedge clk);
        seed_we = 1'b0; in_valid = 1'b0;
        while (!in_ready) @(negedge clk);
        exp = model_byte(32'h0F0F0F0F, 8'h5A, P32);
        check(remainder == exp, "R9", remainder, exp);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule